// File: doc/BRIEF.md
# Interrupt Cause and Enable Controller with Group Summaries

This block gathers up to 29 event lines into a 32-bit pending-cause register. Each cause bit stays set until software clears it. A 32-bit enable register selects which causes may interrupt the CPU. Three positions of the cause word are not storage. Bit 0 is the OR of every source. Bit 30 covers one irregular group of sources and bit 31 covers another, so a handler can learn in one read which group is active.

Software reaches both registers through a small bus with one select per register, a write strobe, write data and combinational read data. A pending cause is acknowledged by writing a word that has a 0 in that position and 1 everywhere else. A read-modify-write that clears one bit therefore never loses events in the other bits. The block drives a registered interrupt request to the CPU. It also outputs the 5-bit number of the most urgent enabled pending source, with a valid flag.

Top module: `irq_cause_ctrl`

## Requirements
- R1: While reset is high and after it falls, the cause read (all 32 bits) and the enable read are zero, and `irq_out` and `src_valid` are low.
- R2: A 1 on `src_evt[i]` at a clock edge sets cause bit i (1 to 29) at that edge. The bit stays set while no write to the cause register clears it.
- R3: A write with `sel_cause` and `wr_en` high clears each source bit where `wdata` holds 0 and leaves each bit where `wdata` holds 1 unchanged.
- R4: When an event and a clearing write hit the same cause bit at the same edge, the bit ends up set.
- R5: Cause read bit 0 is 1 exactly when any of cause bits 1 to 29 is set.
- R6: Cause read bit 30 is 1 exactly when any of cause bits 1 to 20 or 26 to 29 is set.
- R7: Cause read bit 31 is 1 exactly when any of cause bits 1 to 25 is set.
- R8: Write data in cause positions 0, 30 and 31 is ignored. Those positions always show the summaries of R5 to R7, and writing 1 there sets nothing.
- R9: The enable register reads back the last word written with `sel_mask` and `wr_en` high. An enable bit of 1 lets its source interrupt and a 0 blocks it.
- R10: `src_valid` is high exactly when `irq_out` is high. `src_num` then gives the lowest-numbered enabled pending source in 1 to 29.
- R11: `irq_out`, `src_valid` and `src_num` are registered. They follow a change of the cause or enable register one clock later.
- R12: Enable bits 0, 30 and 31 have no effect on `irq_out`, because summary positions are never dispatched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | 29 | Event lines for cause bits 29 down to 1 |
| sel_cause | input | 1 | Selects the cause register (wins reads if both selects are high) |
| sel_mask | input | 1 | Selects the enable register |
| wr_en | input | 1 | Write strobe for the selected register(s) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register, zero when neither is selected |
| irq_out | output | 1 | Registered interrupt request to the CPU |
| src_num | output | 5 | Number of the most urgent enabled pending source |
| src_valid | output | 1 | `src_num` holds a real source |

## Verification
The bench builds the block at its package defaults: 29 sources at positions 1 to 29, a 5-bit source number and the fixed summary groups. This is the only configuration in which both irregular groups exist. The scenarios pick sources on each side of the group edges (20/21 and 25/26) and the extremes 1 and 29, so every summary's inclusion and exclusion can be seen. The bench also holds the outputs at the cycle just after each register change, which separates the registered request from the register contents.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
  localparam int REG_W   = 32;
  localparam int SRC_LO  = 1;
  localparam int SRC_HI  = 29;
  localparam int NUM_SRC = SRC_HI - SRC_LO + 1;
  localparam int NUM_W   = $clog2(SRC_HI + 1);
  localparam int SUM_ANY = 0;
  localparam int SUM_A   = 30;
  localparam int SUM_B   = 31;

  function automatic logic [REG_W-1:0] span(input int lo, input int hi);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < REG_W; i++)
      if (i >= lo && i <= hi) r[i] = 1'b1;
    return r;
  endfunction

  localparam logic [REG_W-1:0] SRC_MASK = span(SRC_LO, SRC_HI);
  localparam logic [REG_W-1:0] GRP_A    = span(26, 29) | span(1, 20);
  localparam logic [REG_W-1:0] GRP_B    = span(1, 25);

  function automatic logic [NUM_W-1:0] first_src(input logic [REG_W-1:0] v);
    logic [NUM_W-1:0] r;
    r = '0;
    for (int i = SRC_HI; i >= SRC_LO; i--)
      if (v[i]) r = i[NUM_W-1:0];
    return r;
  endfunction
endpackage

// File: rtl/irqc_cause_reg.sv
`timescale 1ns/1ps
module irqc_cause_reg import irqc_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cause,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt_vec,
  output logic [REG_W-1:0] cause_q
);
  logic [REG_W-1:0] keep_vec;
  logic [REG_W-1:0] cause_d;

  always_comb begin
    keep_vec = wr_cause ? wdata : '1;
    cause_d  = ((cause_q & keep_vec) | evt_vec) & SRC_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) cause_q <= '0;
    else     cause_q <= cause_d;
  end
endmodule

// File: rtl/irqc_summary.sv
`timescale 1ns/1ps
module irqc_summary import irqc_pkg::*; (
  input  logic [REG_W-1:0] cause_q,
  output logic [REG_W-1:0] cause_view
);
  logic [REG_W-1:0] src_only;

  always_comb begin
    src_only           = cause_q & SRC_MASK;
    cause_view         = src_only;
    cause_view[SUM_ANY] = |src_only;
    cause_view[SUM_A]   = |(src_only & GRP_A);
    cause_view[SUM_B]   = |(src_only & GRP_B);
  end
endmodule

// File: rtl/irqc_prio_enc.sv
`timescale 1ns/1ps
module irqc_prio_enc import irqc_pkg::*; (
  input  logic [REG_W-1:0] pend_vec,
  output logic [NUM_W-1:0] first_num,
  output logic             pend_any
);
  always_comb begin
    pend_any  = |(pend_vec & SRC_MASK);
    first_num = first_src(pend_vec & SRC_MASK);
  end
endmodule

// File: rtl/irq_cause_ctrl.sv
`timescale 1ns/1ps
module irq_cause_ctrl import irqc_pkg::*; (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SRC_HI:SRC_LO]  src_evt,
  input  logic                  sel_cause,
  input  logic                  sel_mask,
  input  logic                  wr_en,
  input  logic [REG_W-1:0]      wdata,
  output logic [REG_W-1:0]      rdata,
  output logic                  irq_out,
  output logic [NUM_W-1:0]      src_num,
  output logic                  src_valid
);
  logic             wr_cause;
  logic             wr_mask;
  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] cause_q;
  logic [REG_W-1:0] cause_view;
  logic [REG_W-1:0] mask_q;
  logic [REG_W-1:0] pend_vec;
  logic [NUM_W-1:0] first_num;
  logic             pend_any;

  assign wr_cause = wr_en & sel_cause;
  assign wr_mask  = wr_en & sel_mask;
  assign evt_vec  = {{(REG_W-1-SRC_HI){1'b0}}, src_evt, {SRC_LO{1'b0}}};
  assign pend_vec = cause_q & mask_q;

  irqc_cause_reg u_cause (
    .clk      (clk),
    .rst      (rst),
    .wr_cause (wr_cause),
    .wdata    (wdata),
    .evt_vec  (evt_vec),
    .cause_q  (cause_q)
  );

  irqc_summary u_sum (
    .cause_q    (cause_q),
    .cause_view (cause_view)
  );

  irqc_prio_enc u_prio (
    .pend_vec  (pend_vec),
    .first_num (first_num),
    .pend_any  (pend_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      irq_out   <= 1'b0;
      src_valid <= 1'b0;
      src_num   <= '0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      irq_out   <= pend_any;
      src_valid <= pend_any;
      src_num   <= pend_any ? first_num : '0;
    end
  end

  always_comb begin
    if (sel_cause)     rdata = cause_view;
    else if (sel_mask) rdata = mask_q;
    else               rdata = '0;
  end
endmodule

// File: rtl/irqc_checker.sv
`timescale 1ns/1ps
module irqc_checker import irqc_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             wr_cause,
  input logic             wr_mask,
  input logic [REG_W-1:0] wdata,
  input logic [REG_W-1:0] evt_vec,
  input logic [REG_W-1:0] cause_q,
  input logic [REG_W-1:0] mask_q,
  input logic             pend_any,
  input logic             irq_out,
  input logic [NUM_W-1:0] src_num,
  input logic             src_valid
);
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_cause)) |-> ((cause_q & $past(cause_q)) == $past(cause_q)));

  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_cause)) |-> ((cause_q & ~($past(wdata) | $past(evt_vec))) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cause_q & $past(evt_vec)) == $past(evt_vec)));

  p_mask_load_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_mask)) |-> (mask_q == $past(wdata)));

  p_valid_irq_r10: assert property (@(posedge clk) disable iff (rst)
    src_valid == irq_out);

  p_num_range_r10: assert property (@(posedge clk) disable iff (rst)
    src_valid |-> (src_num >= NUM_W'(SRC_LO) && src_num <= NUM_W'(SRC_HI)));

  p_irq_delay_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == $past(pend_any)));
endmodule

bind irq_cause_ctrl irqc_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_cause  (wr_cause),
  .wr_mask   (wr_mask),
  .wdata     (wdata),
  .evt_vec   (evt_vec),
  .cause_q   (cause_q),
  .mask_q    (mask_q),
  .pend_any  (pend_any),
  .irq_out   (irq_out),
  .src_num   (src_num),
  .src_valid (src_valid)
);

// File: tb/irq_cause_ctrl_test.sv
`timescale 1ns/1ps
module irq_cause_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:1] src_evt = '0;
  logic        sel_cause = 1'b0;
  logic        sel_mask = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_out;
  logic [4:0]  src_num;
  logic        src_valid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] m_cause = '0;
  logic [31:0] m_mask = '0;

  always #2.5 clk = ~clk;

  irq_cause_ctrl uut (
    .clk(clk), .rst(rst), .src_evt(src_evt), .sel_cause(sel_cause),
    .sel_mask(sel_mask), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .irq_out(irq_out), .src_num(src_num), .src_valid(src_valid)
  );

  function automatic logic [31:0] view_of(input logic [31:0] c);
    logic [31:0] v;
    v = '0;
    for (int i = 1; i <= 29; i++) begin
      if (c[i]) begin
        v[i] = 1'b1;
        v[0] = 1'b1;
        if (i <= 20 || i >= 26) v[30] = 1'b1;
        if (i <= 25) v[31] = 1'b1;
      end
    end
    return v;
  endfunction

  function automatic int top_src(input logic [31:0] c, input logic [31:0] m);
    for (int i = 1; i <= 29; i++)
      if (c[i] && m[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input bit cause, output logic [31:0] d);
    @(negedge clk);
    sel_cause = cause;
    sel_mask  = !cause;
    #1 d = rdata;
    sel_cause = 1'b0;
    sel_mask  = 1'b0;
  endtask

  task automatic wr(input bit cause, input logic [31:0] d);
    @(negedge clk);
    sel_cause = cause;
    sel_mask  = !cause;
    wr_en = 1'b1;
    wdata = d;
    @(negedge clk);
    sel_cause = 1'b0; sel_mask = 1'b0; wr_en = 1'b0; wdata = '0;
    if (cause) m_cause = m_cause & d & 32'h3FFF_FFFE;
    else       m_mask  = d;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    src_evt = v[29:1];
    @(negedge clk);
    src_evt = '0;
    m_cause = m_cause | (v & 32'h3FFF_FFFE);
  endtask

  task automatic chk_out(input string req);
    int s;
    s = top_src(m_cause, m_mask);
    chk({req, " irq"}, {31'b0, irq_out}, {31'b0, s != 0});
    chk({req, " valid"}, {31'b0, src_valid}, {31'b0, s != 0});
    if (s != 0) chk({req, " num"}, {27'b0, src_num}, s[31:0]);
  endtask

  task automatic chk_cause(input string req);
    logic [31:0] d;
    rd(1'b1, d);
    chk(req, d, view_of(m_cause));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(1'b1, d); chk("R1 cause in reset", d, 32'h0);
    chk("R1 irq in reset", {31'b0, irq_out}, 32'h0);
    @(negedge clk); rst = 1'b0;
    rd(1'b1, d); chk("R1 cause", d, 32'h0);
    rd(1'b0, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    chk("R1 valid", {31'b0, src_valid}, 32'h0);
  endtask

  task automatic t_sticky;
    pulse(32'h1 << 5);
    repeat (3) @(negedge clk);
    chk_cause("R2 sticky bit 5 with R5 R6 R7 summaries");
    chk_out("R9 masked source blocked");
  endtask

  task automatic t_groups;
    int bits[6] = '{1, 20, 21, 25, 26, 29};
    foreach (bits[k]) begin
      wr(1'b1, 32'h0);
      chk_cause("R3 clear all");
      pulse(32'h1 << bits[k]);
      chk_cause($sformatf("R5 R6 R7 groups for source %0d", bits[k]));
    end
  endtask

  task automatic t_clear;
    wr(1'b1, 32'h0);
    pulse((32'h1 << 3) | (32'h1 << 7) | (32'h1 << 12));
    wr(1'b1, ~(32'h1 << 7));
    chk_cause("R3 clear one keeps others");
  endtask

  task automatic t_race;
    pulse(32'h1 << 9);
    @(negedge clk);
    sel_cause = 1'b1; wr_en = 1'b1; wdata = 32'h0;
    src_evt = 29'h1 << 8;
    @(negedge clk);
    sel_cause = 1'b0; wr_en = 1'b0; src_evt = '0;
    m_cause = 32'h1 << 9;
    chk_cause("R4 set beats clear");
  endtask

  task automatic t_summary_write;
    logic [31:0] d;
    wr(1'b1, 32'h0);
    wr(1'b1, 32'hC000_0001);
    rd(1'b1, d); chk("R8 write ones to summaries sets nothing", d, 32'h0);
    pulse(32'h1 << 22);
    wr(1'b1, 32'h3FFF_FFFE);
    chk_cause("R8 zeros at summary positions ignored");
  endtask

  task automatic t_mask_prio;
    logic [31:0] d;
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, d); chk("R9 mask readback", d, 32'hFFFF_FFFF);
    pulse((32'h1 << 20) | (32'h1 << 4));
    chk("R11 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk_out("R10 lowest source wins");
    wr(1'b1, ~(32'h1 << 4));
    chk("R11 num holds one cycle", {27'b0, src_num}, 32'd4);
    @(negedge clk);
    chk_out("R10 next source after clear");
    wr(1'b0, ~(32'h1 << 20));
    chk("R11 irq holds one cycle", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    chk_out("R9 mask 0 blocks");
  endtask

  task automatic t_mask_summary;
    wr(1'b1, 32'h0);
    wr(1'b0, 32'hC000_0001);
    pulse(32'h1 << 15);
    @(negedge clk);
    chk_out("R12 summary enables ignored");
    wr(1'b0, 32'h1 << 29);
    pulse(32'h1 << 29);
    @(negedge clk);
    chk_out("R10 highest source number 29");
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    t_sticky;
    t_groups;
    t_clear;
    t_race;
    t_summary_write;
    t_mask_prio;
    t_mask_summary;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule